// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence for a four-beat burst in front of a synchronous memory. On a load cycle it captures a full external address and the burst-order selection. On each following advance cycle it steps a two-bit beat counter and derives the two low-order address bits from the captured start offset. The upper address bits stay at their loaded value for the whole burst.

Two orders are supported. Linear order adds the beat index to the start offset modulo four. Interleaved order XORs the start offset with the beat index. Advancing past the fourth beat wraps inside the same aligned four-address block. A clock enable suspends the block: while it is low every input is ignored and every register holds its value. Memory access and data movement are handled elsewhere.

Top module: `burst_addr_gen`

## Requirements
- R1: While rstN is low, and in the first cycle after it rises with no load, addrOut is 0 and beatIdx is 0.
- R2: A cycle with clkEn=1 and advance=0 is a load. After that edge addrOut equals the addrIn sampled at the edge and beatIdx is 0.
- R3: A cycle with clkEn=1 and advance=1 is an advance. After that edge beatIdx equals its previous value plus one modulo 4, so it goes 0,1,2,3,0,...
- R4: When interleave=0 at the load (linear order), addrOut[1:0] after each edge equals (start + beatIdx) mod 4, where start is addrIn[1:0] at the load. For example, start 1 gives 1,2,3,0.
- R5: When interleave=1 at the load (interleaved order), addrOut[1:0] equals start XOR beatIdx. For example, start 1 gives 1,0,3,2.
- R6: An advance leaves addrOut[ADDR_W-1:2] unchanged, including when the low bits wrap from 3 to 0 and when the upper bits are all ones.
- R7: A cycle with clkEn=0 changes neither addrOut nor beatIdx, whatever advance, interleave and addrIn are.
- R8: The order is taken from interleave only at a load. Changing interleave during advance cycles has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Clock enable. Low suspends the block. |
| advance | input | 1 | 1 = step the burst, 0 = load a new address |
| interleave | input | 1 | Burst order captured at a load: 0 = linear, 1 = interleaved |
| addrIn | input | ADDR_W | External start address |
| addrOut | output | ADDR_W | Current burst address |
| beatIdx | output | BEAT_W | Beat number within the burst, 0 at a load |

## Verification
Two cases are hard to reach from the ports. The first is a wrap-around that would carry into the upper address bits. The bench loads a start address whose upper bits are all ones and runs six advances from every start offset, so the low bits wrap while a carry would be visible. The second is a change of order or address that must not act in the middle of a burst. The bench inserts a suspended cycle carrying a different address and the opposite order, and toggles the order input on every advance. The sequence must still follow the order captured at the load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;

  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burstOrder_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advance,
  input  logic              interleave,
  output ctrlStrobes_t      strobes,
  output logic [BEAT_W-1:0] beatIdx,
  output burstOrder_e       order
);

  localparam logic [BEAT_W-1:0] BEAT_ONE  = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] BEAT_ZERO = '0;

  logic [BEAT_W-1:0] beatQ;
  burstOrder_e       orderQ;

  // Every enabled cycle is either a load or a step.
  always_comb begin
    strobes.load = clkEn & ~advance;
    strobes.step = clkEn & advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatQ  <= BEAT_ZERO;
      orderQ <= ORDER_LINEAR;
    end else if (strobes.load) begin
      beatQ  <= BEAT_ZERO;
      orderQ <= interleave ? ORDER_INTERLEAVED : ORDER_LINEAR;
    end else if (strobes.step) begin
      beatQ  <= beatQ + BEAT_ONE;
    end
  end

  assign beatIdx = beatQ;
  assign order   = orderQ;

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [BEAT_W-1:0] beatIdx,
  input  burstOrder_e       order,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] startLow;
  logic [BEAT_W-1:0] linLow;
  logic [BEAT_W-1:0] intLow;
  logic [BEAT_W-1:0] curLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             baseQ <= '0;
    else if (strobes.load) baseQ <= addrIn;
  end

  assign startLow = baseQ[BEAT_W-1:0];

  // The sum is kept at BEAT_W bits, so a wrap never reaches the upper bits.
  assign linLow = startLow + beatIdx;

  // Interleaved order: one XOR per offset bit.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_intl
    assign intLow[b] = startLow[b] ^ beatIdx[b];
  end

  always_comb begin
    unique case (order)
      ORDER_INTERLEAVED: curLow = intLow;
      default:           curLow = linLow;
    endcase
  end

  assign addrOut = {baseQ[ADDR_W-1 -: UPPER_W], curLow};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BEAT_W-1:0] beatIdx
);

  ctrlStrobes_t strobes;
  burstOrder_e  order;

  burst_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .advance    (advance),
    .interleave (interleave),
    .strobes    (strobes),
    .beatIdx    (beatIdx),
    .order      (order)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addrIn  (addrIn),
    .beatIdx (beatIdx),
    .order   (order),
    .addrOut (addrOut)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              advance,
  input logic              interleave,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [BEAT_W-1:0] beatIdx
);

  // Start offset and order, tracked from the ports at each load.
  logic [BEAT_W-1:0] seenStart;
  logic              seenIntl;
  logic [BEAT_W-1:0] expLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenStart <= '0;
      seenIntl  <= 1'b0;
    end else if (clkEn && !advance) begin
      seenStart <= addrIn[BEAT_W-1:0];
      seenIntl  <= interleave;
    end
  end

  always_comb begin
    if (seenIntl) expLow = seenStart ^ beatIdx;
    else          expLow = seenStart + beatIdx;
  end

  // R1
  always_comb begin
    if (!rstN) begin
      a_r1_reset_zero: assert (addrOut == '0 && beatIdx == '0);
    end
  end

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advance) |=> (addrOut == $past(addrIn) && beatIdx == '0));

  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance) |=> (beatIdx == BEAT_W'($past(beatIdx) + 1'b1)));

  // R4 and R5
  a_r4_r5_low_order: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance) |=> (addrOut[BEAT_W-1:0] == expLow));

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance) |=> $stable(addrOut[ADDR_W-1:BEAT_W]));

  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn) |=> ($stable(addrOut) && $stable(beatIdx)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .advance    (advance),
  .interleave (interleave),
  .addrIn     (addrIn),
  .addrOut    (addrOut),
  .beatIdx    (beatIdx)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int ADDR_W = 20;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEn = 1'b0;
  logic              advance = 1'b0;
  logic              interleave = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ADDR_W-1:0] addrOut;
  logic [BEAT_W-1:0] beatIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model of the expected state
  logic [ADDR_W-1:0] mBase = '0;
  bit                mIntl = 1'b0;
  int                mBeat = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advance(advance),
    .interleave(interleave), .addrIn(addrIn), .addrOut(addrOut), .beatIdx(beatIdx)
  );

  function automatic logic [ADDR_W-1:0] expAddr();
    int s;
    int low;
    s = int'(mBase[1:0]);
    low = mIntl ? (s ^ mBeat) : ((s + mBeat) % 4);
    return {mBase[ADDR_W-1:2], 2'(low)};
  endfunction

  task automatic check(input string req);
    checks++;
    if (addrOut !== expAddr() || beatIdx !== 2'(mBeat)) begin
      errors++;
      $display("FAIL %s: addrOut=%h beatIdx=%0d expected addrOut=%h beatIdx=%0d",
               req, addrOut, beatIdx, expAddr(), mBeat);
    end
  endtask

  // Drive at a falling edge; the model follows the next rising edge.
  task automatic cycle(input bit ce, input bit adv, input bit il, input logic [ADDR_W-1:0] a);
    clkEn = ce; advance = adv; interleave = il; addrIn = a;
    @(negedge clk);
    if (ce && !adv) begin
      mBase = a; mIntl = il; mBeat = 0;
    end else if (ce && adv) begin
      mBeat = (mBeat + 1) % 4;
    end
  endtask

  initial begin
    logic [ADDR_W-1:0] uppers [3];
    string ordReq;
    uppers[0] = 20'h00000;
    uppers[1] = 20'hFFFFC;
    uppers[2] = 20'h5A5A4;

    @(negedge clk);
    check("R1");
    @(negedge clk);
    rstN = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, 20'h12345);
    check("R1");

    for (int u = 0; u < 3; u++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          ordReq = (m != 0) ? "R5/R6/R8" : "R4/R6/R8";
          cycle(1'b1, 1'b0, bit'(m), uppers[u] | ADDR_W'(s));
          check("R2");
          for (int k = 0; k < 6; k++) begin
            // The order input toggles on every advance (R8).
            cycle(1'b1, 1'b1, bit'((m + k + 1) % 2), uppers[u] ^ 20'hABCDE);
            check((k == 0) ? "R3" : ordReq);
            if (k == 1) begin
              cycle(1'b0, 1'b0, bit'(1 - m), 20'h0F0F3);
              check("R7");
            end
          end
        end
      end
    end

    // Back-to-back loads with different addresses
    cycle(1'b1, 1'b0, 1'b1, 20'h3C3C2);
    check("R2");
    cycle(1'b1, 1'b0, 1'b0, 20'hC3C3D);
    check("R2");
    cycle(1'b1, 1'b1, 1'b1, 20'h00000);
    check("R4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule